// File: doc/BRIEF.md
# EDAC Read-Modify-Write Mode Controller

This block is the control and latching datapath that sits between a memory data bus and an error detection and correction codec. A two-bit mode input picks one of four operations: check-word generation for a memory write, a read that raises error flags, a read that presents the corrected word, and a diagnostic readback of the raw input latches. The codec is outside the block. The block presents the word to evaluate on `codec_dat`/`codec_chk`. It takes back the syndrome, the single and multiple error flags, the corrected word and the freshly generated check bits.

A partial-word write works as a read-modify-write. First the stored word is read and flagged. Then the corrected word is loaded into an output latch under its own enable. In generate mode, each byte whose output enable is set keeps the held byte, and each other byte takes the new bus byte. The merged word is then written back with check bits computed from the merged word itself. When all byte enables are clear, generate mode reduces to a plain write of the new bus word. If the load that filled the output latch saw a multiple-bit error, the block holds a sticky error bit and suppresses the write strobe.

Top module: `edac_rmw_ctl`

## Requirements
- R1: Synchronous active-high reset clears the input data/check latches, the output latch and the sticky error bit. After reset, `dout` reads 0 in mode 10 and mode 11, and `wr_stb` follows `wr_req` in mode 00.
- R2: Mode encoding: 00 generate, 01 read-flag, 10 read-correct, 11 diagnostic. In mode 01 the input latches capture `mem_dat`/`mem_chk` at every rising edge, and in all other modes they hold. In the read modes `codec_dat`/`codec_chk` present the latched values.
- R3: `err_single`/`err_multi` follow `cdc_single`/`cdc_multi` in modes 01 and 10, and are 0 in modes 00 and 11.
- R4: In mode 10 with `olat_en` high, the output latch loads `cdc_fixed` at the rising edge. In modes 01 and 10, `dout` shows the output latch.
- R5: While `olat_en` is low, or the mode is not 10, the output latch keeps its value whatever the data inputs do.
- R6: In mode 11, `dout` equals the input data latch and `chk_out` equals the input check latch.
- R7: `dout_en[b]` equals `byte_oe[b]` in modes 01, 10 and 11, and is all zero in mode 00.
- R8: In mode 00, byte b of `wr_dat` (bits 8b+7 down to 8b) is the output-latch byte when `byte_oe[b]` is 1, and the `new_dat` byte when it is 0.
- R9: In mode 00, `codec_dat` carries the merged word and `codec_chk` is 0. `wr_chk` and `chk_out` equal `cdc_gen`, the check bits of the merged word.
- R10: Each output-latch load sets the sticky bit to `cdc_multi`. `wr_stb` is high only in mode 00 with `wr_req` high and the sticky bit clear.
- R11: In modes 01 and 10, `chk_out` equals `cdc_syn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operation select (00 gen, 01 read-flag, 10 read-correct, 11 diag) |
| olat_en | input | 1 | Output latch load enable |
| byte_oe | input | DATA_W/BYTE_W | Per-byte output enable / keep-held-byte select |
| wr_req | input | 1 | Write-back request |
| mem_dat | input | DATA_W | Data word from memory |
| mem_chk | input | CHK_W | Check word from memory |
| new_dat | input | DATA_W | Replacement / new write data from the bus |
| cdc_syn | input | CHK_W | Codec syndrome |
| cdc_single | input | 1 | Codec single-error flag |
| cdc_multi | input | 1 | Codec multiple-error flag |
| cdc_fixed | input | DATA_W | Codec corrected data |
| cdc_gen | input | CHK_W | Codec generated check bits of `codec_dat` |
| codec_dat | output | DATA_W | Data word presented to the codec |
| codec_chk | output | CHK_W | Check word presented to the codec |
| dout | output | DATA_W | Output data bus value |
| dout_en | output | DATA_W/BYTE_W | Per-byte drive enable of `dout` |
| chk_out | output | CHK_W | Syndrome, generated check or latched check |
| err_single | output | 1 | Single-error flag |
| err_multi | output | 1 | Multiple-error flag |
| wr_dat | output | DATA_W | Merged write-back data |
| wr_chk | output | CHK_W | Check bits for the write-back |
| wr_stb | output | 1 | Write-back strobe |

## Verification
The bench builds the block with its default widths: a 32-bit word, 8-bit bytes and a 7-bit check word, which gives four byte lanes. With four lanes it can drive byte-enable patterns that are full, empty, alternating and single-lane through a complete read, correct, merge and write-back sequence. It pairs them with clean, single-error and multiple-error reads from a simple codec model of its own. Directed cases cover latch hold, diagnostic readback and the clearing of the sticky bit by reset.

// File: rtl/edac_rmw_pkg.sv
package edac_rmw_pkg;

    typedef enum logic [1:0] {
        MODE_GEN   = 2'b00,
        MODE_RFLAG = 2'b01,
        MODE_RCORR = 2'b10,
        MODE_DIAG  = 2'b11
    } edac_mode_e;

    typedef struct packed {
        logic single;
        logic multi;
    } edac_flags_t;

    function automatic logic mode_is_read(edac_mode_e m);
        return (m == MODE_RFLAG) || (m == MODE_RCORR);
    endfunction

endpackage

// File: rtl/edac_in_latch.sv
module edac_in_latch #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d_in,
    input  logic [CHK_W-1:0]  c_in,
    output logic [DATA_W-1:0] d_q,
    output logic [CHK_W-1:0]  c_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
            c_q <= '0;
        end else if (load) begin
            d_q <= d_in;
            c_q <= c_in;
        end
    end
endmodule

// File: rtl/edac_out_latch.sv
module edac_out_latch #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] fixed,
    input  logic              multi,
    output logic [DATA_W-1:0] d_q,
    output logic              sticky_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_q      <= '0;
            sticky_q <= 1'b0;
        end else if (load) begin
            d_q      <= fixed;
            sticky_q <= multi;
        end
    end
endmodule

// File: rtl/edac_byte_merge.sv
module edac_byte_merge #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] held,
    input  logic [DATA_W-1:0] repl,
    input  logic [NBYTES-1:0] keep,
    output logic [DATA_W-1:0] merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[b*BYTE_W +: BYTE_W] =
            keep[b] ? held[b*BYTE_W +: BYTE_W] : repl[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/edac_rmw_ctl.sv
module edac_rmw_ctl
    import edac_rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int CHK_W  = 7,
    localparam int NBYTES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              olat_en,
    input  logic [NBYTES-1:0] byte_oe,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] mem_dat,
    input  logic [CHK_W-1:0]  mem_chk,
    input  logic [DATA_W-1:0] new_dat,
    input  logic [CHK_W-1:0]  cdc_syn,
    input  logic              cdc_single,
    input  logic              cdc_multi,
    input  logic [DATA_W-1:0] cdc_fixed,
    input  logic [CHK_W-1:0]  cdc_gen,
    output logic [DATA_W-1:0] codec_dat,
    output logic [CHK_W-1:0]  codec_chk,
    output logic [DATA_W-1:0] dout,
    output logic [NBYTES-1:0] dout_en,
    output logic [CHK_W-1:0]  chk_out,
    output logic              err_single,
    output logic              err_multi,
    output logic [DATA_W-1:0] wr_dat,
    output logic [CHK_W-1:0]  wr_chk,
    output logic              wr_stb
);
    edac_mode_e          md;
    logic                rd_mode;
    logic                in_load;
    logic                olat_load;
    logic [DATA_W-1:0]   in_d;
    logic [CHK_W-1:0]    in_c;
    logic [DATA_W-1:0]   olat_d;
    logic                sticky;
    logic [DATA_W-1:0]   merged;
    edac_flags_t         flags;

    assign md        = edac_mode_e'(mode);
    assign rd_mode   = mode_is_read(md);
    assign in_load   = (md == MODE_RFLAG);
    assign olat_load = (md == MODE_RCORR) && olat_en;

    edac_in_latch #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_in (
        .clk(clk), .rst(rst), .load(in_load),
        .d_in(mem_dat), .c_in(mem_chk), .d_q(in_d), .c_q(in_c)
    );

    edac_out_latch #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .load(olat_load),
        .fixed(cdc_fixed), .multi(cdc_multi), .d_q(olat_d), .sticky_q(sticky)
    );

    edac_byte_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
        .held(olat_d), .repl(new_dat), .keep(byte_oe), .merged(merged)
    );

    always_comb begin
        flags.single = rd_mode & cdc_single;
        flags.multi  = rd_mode & cdc_multi;
    end
    assign err_single = flags.single;
    assign err_multi  = flags.multi;

    always_comb begin
        codec_dat = in_d;
        codec_chk = in_c;
        dout      = olat_d;
        chk_out   = cdc_syn;
        dout_en   = byte_oe;
        wr_dat    = '0;
        wr_chk    = '0;
        wr_stb    = 1'b0;
        case (md)
            MODE_GEN: begin
                codec_dat = merged;
                codec_chk = '0;
                dout      = '0;
                chk_out   = cdc_gen;
                dout_en   = '0;
                wr_dat    = merged;
                wr_chk    = cdc_gen;
                wr_stb    = wr_req & ~sticky;
            end
            MODE_DIAG: begin
                dout    = in_d;
                chk_out = in_c;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/edac_rmw_ctl_chk.sv
module edac_rmw_ctl_chk #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7,
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              olat_load,
    input logic              cdc_multi,
    input logic [DATA_W-1:0] cdc_fixed,
    input logic [DATA_W-1:0] olat_d,
    input logic [DATA_W-1:0] in_d,
    input logic [DATA_W-1:0] dout,
    input logic [NBYTES-1:0] dout_en,
    input logic              wr_stb
);
    AST_OLAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !olat_load |=> $stable(olat_d)); // R5
    AST_OLAT_LOAD: assert property (@(posedge clk) disable iff (rst)
        olat_load |=> (olat_d == $past(cdc_fixed))); // R4
    AST_INLAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b01) |=> $stable(in_d)); // R2
    AST_MULTI_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (olat_load && cdc_multi) |=> !wr_stb); // R10
    AST_GEN_NODRIVE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> (dout_en == '0)); // R7
    AST_DIAG_READ: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |-> (dout == in_d)); // R6
endmodule

bind edac_rmw_ctl edac_rmw_ctl_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W), .NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .olat_load(olat_load),
    .cdc_multi(cdc_multi), .cdc_fixed(cdc_fixed), .olat_d(olat_d),
    .in_d(in_d), .dout(dout), .dout_en(dout_en), .wr_stb(wr_stb)
);

// File: tb/edac_rmw_ctl_tb_top.sv
module edac_rmw_ctl_tb_top;
    localparam int DW = 32;
    localparam int BW = 8;
    localparam int CW = 7;
    localparam int NB = DW / BW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic olat_en = 1'b0;
    logic [NB-1:0] byte_oe = '0;
    logic wr_req = 1'b0;
    logic [DW-1:0] mem_dat = '0;
    logic [CW-1:0] mem_chk = '0;
    logic [DW-1:0] new_dat = '0;
    logic [CW-1:0] cdc_syn;
    logic cdc_single, cdc_multi;
    logic [DW-1:0] cdc_fixed;
    logic [CW-1:0] cdc_gen;
    logic [DW-1:0] codec_dat, dout, wr_dat;
    logic [CW-1:0] codec_chk, chk_out, wr_chk;
    logic [NB-1:0] dout_en;
    logic err_single, err_multi, wr_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [CW-1:0] gen_f(logic [DW-1:0] d);
        logic [CW-1:0] g = '0;
        for (int i = 0; i < DW; i++) g[i % CW] ^= d[i];
        return g;
    endfunction
    function automatic logic [CW-1:0] syn_f(logic [DW-1:0] d, logic [CW-1:0] c);
        return gen_f(d) ^ c;
    endfunction
    function automatic logic single_f(logic [CW-1:0] s);
        return ^s;
    endfunction
    function automatic logic multi_f(logic [CW-1:0] s);
        return (s != '0) && !(^s);
    endfunction
    function automatic logic [DW-1:0] fix_f(logic [DW-1:0] d, logic [CW-1:0] s);
        return single_f(s) ? (d ^ (DW'(1) << (s % DW))) : d;
    endfunction
    function automatic logic [DW-1:0] merge_f(logic [DW-1:0] h, logic [DW-1:0] n, logic [NB-1:0] k);
        logic [DW-1:0] m;
        for (int b = 0; b < NB; b++)
            m[b*BW +: BW] = k[b] ? h[b*BW +: BW] : n[b*BW +: BW];
        return m;
    endfunction

    // Codec model driven from the block's codec-side outputs
    always_comb begin
        cdc_syn    = syn_f(codec_dat, codec_chk);
        cdc_single = single_f(cdc_syn);
        cdc_multi  = multi_f(cdc_syn);
        cdc_fixed  = fix_f(codec_dat, cdc_syn);
        cdc_gen    = gen_f(codec_dat);
    end

    edac_rmw_ctl #(.DATA_W(DW), .BYTE_W(BW), .CHK_W(CW)) dut_i (
        .clk(clk), .rst(rst), .mode(mode), .olat_en(olat_en), .byte_oe(byte_oe),
        .wr_req(wr_req), .mem_dat(mem_dat), .mem_chk(mem_chk), .new_dat(new_dat),
        .cdc_syn(cdc_syn), .cdc_single(cdc_single), .cdc_multi(cdc_multi),
        .cdc_fixed(cdc_fixed), .cdc_gen(cdc_gen), .codec_dat(codec_dat),
        .codec_chk(codec_chk), .dout(dout), .dout_en(dout_en), .chk_out(chk_out),
        .err_single(err_single), .err_multi(err_multi), .wr_dat(wr_dat),
        .wr_chk(wr_chk), .wr_stb(wr_stb)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic [DW-1:0] dat;
        logic [CW-1:0] flip;
        logic [DW-1:0] nw;
        logic [NB-1:0] oe;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 7'h00, 32'hAABB_CCDD, 4'b1010},
        '{32'hDEAD_BEEF, 7'h01, 32'h0102_0304, 4'b0001},
        '{32'h0F0F_F0F0, 7'h04, 32'h5555_AAAA, 4'b1111},
        '{32'hCAFE_0001, 7'h00, 32'h9988_7766, 4'b0000},
        '{32'h0000_0000, 7'h03, 32'hFFFF_0000, 4'b0110},
        '{32'h8765_4321, 7'h06, 32'h1111_2222, 4'b1000}
    };

    logic [DW-1:0] last_fix;

    initial begin
        logic [CW-1:0] c, s;
        logic [DW-1:0] fx, mg;
        // Reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mode = 2'b10;
        byte_oe = 4'b1111;
        #1;
        check("R1 dout after reset", 64'(dout), 64'h0);
        mode = 2'b11;
        #1;
        check("R1 diag data after reset", 64'(dout), 64'h0);
        check("R1 diag chk after reset", 64'(chk_out), 64'h0);
        mode = 2'b00;
        wr_req = 1'b1;
        #1;
        check("R1 strobe after reset", 64'(wr_stb), 64'h1);
        wr_req = 1'b0;

        for (int v = 0; v < NV; v++) begin
            c  = gen_f(VECS[v].dat) ^ VECS[v].flip;
            s  = VECS[v].flip;
            fx = fix_f(VECS[v].dat, s);
            mg = merge_f(fx, VECS[v].nw, VECS[v].oe);
            @(negedge clk);
            mode = 2'b01;
            mem_dat = VECS[v].dat;
            mem_chk = c;
            byte_oe = VECS[v].oe;
            step();
            check("R2 codec data", 64'(codec_dat), 64'(VECS[v].dat));
            check("R2 codec chk", 64'(codec_chk), 64'(c));
            check("R3 single flag", 64'(err_single), 64'(single_f(s)));
            check("R3 multi flag", 64'(err_multi), 64'(multi_f(s)));
            check("R11 syndrome out", 64'(chk_out), 64'(s));
            @(negedge clk);
            mode = 2'b10;
            olat_en = 1'b1;
            mem_dat = ~VECS[v].dat;
            step();
            check("R4 corrected latched", 64'(dout), 64'(fx));
            check("R7 enables read", 64'(dout_en), 64'(VECS[v].oe));
            @(negedge clk);
            olat_en = 1'b0;
            mode = 2'b00;
            new_dat = VECS[v].nw;
            wr_req = 1'b1;
            #1;
            check("R8 merged write data", 64'(wr_dat), 64'(mg));
            check("R9 write check", 64'(wr_chk), 64'(gen_f(mg)));
            check("R9 codec chk zero", 64'(codec_chk), 64'h0);
            check("R10 strobe", 64'(wr_stb), 64'(!multi_f(s)));
            check("R7 enables gen", 64'(dout_en), 64'h0);
            check("R3 flags gen", 64'({err_single, err_multi}), 64'h0);
            step();
            wr_req = 1'b0;
            mode = 2'b11;
            #1;
            check("R6 diag data", 64'(dout), 64'(VECS[v].dat));
            check("R6 diag chk", 64'(chk_out), 64'(c));
            check("R3 flags diag", 64'({err_single, err_multi}), 64'h0);
            last_fix = fx;
        end

        // Output latch holds while its enable is low
        @(negedge clk);
        mode = 2'b01;
        mem_dat = 32'h0BAD_F00D;
        mem_chk = gen_f(32'h0BAD_F00D) ^ 7'h01;
        step();
        check("R5 hold in read-flag", 64'(dout), 64'(last_fix));
        @(negedge clk);
        mode = 2'b10;
        olat_en = 1'b0;
        mem_dat = 32'h1357_9BDF;
        step();
        step();
        check("R5 hold in read-correct", 64'(dout), 64'(last_fix));
        check("R2 input latch holds in mode 10", 64'(codec_dat), 64'h0BAD_F00D);

        // Last vector was a multiple error: strobe blocked until reset
        @(negedge clk);
        mode = 2'b00;
        wr_req = 1'b1;
        #1;
        check("R10 sticky blocks strobe", 64'(wr_stb), 64'h0);
        rst = 1'b1;
        step();
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset clears sticky", 64'(wr_stb), 64'h1);
        check("R1 reset clears latch", 64'(wr_dat), 64'(merge_f('0, new_dat, byte_oe)));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule